// File: doc/BRIEF.md
# Reset-Time Configuration Byte Loader

After every system reset this block fetches a short list of protected configuration entries from a nonvolatile information area. It uses a synchronous read port with one cycle of latency. Every entry is 16 bits wide: the value sits in the low byte and its bitwise complement sits in the high byte. The block validates each pair and replaces any corrupt pair with an all-ones image. From the accepted values it derives an access-protection level and the watchdog and low-power reset controls that the rest of the chip consumes.

Loading starts by itself when reset is released and runs to completion with no further input. Until the last entry has been captured, every output holds a conservative value: protection at the low level, the watchdog enabled, and resets on low-power entry enabled. A change to the nonvolatile contents is not seen until the next reset.

Top module: `optld_top`

## Requirements
- R1: The cycle after reset release is idle. The block then issues exactly one single-cycle read per word, at `BASE_ADDR` and then at `BASE_ADDR+4`. Each read is followed by one non-read cycle, and no read is issued once `done` is high.
- R2: `done` goes high on the fifth rising edge after reset release, which is two cycles per word plus the idle cycle. It stays high until the next reset.
- R3: A pair {high, low} is accepted when high equals the bitwise inverse of low. The pair 0xFF/0xFF is also accepted. Any other pair, including 0x00/0x00 and any single-bit flip in either byte, is rejected.
- R4: A rejected pair sets `pair_err`, and both its value byte and its complement byte are stored as 0xFF.
- R5: Reset clears `pair_err`. Outputs are taken only from the load that follows a reset: contents that change after `done` have no effect until the next reset.
- R6: The protection value decodes to a `prot_lvl` code: 0xA5 gives 0 (off), 0xCC gives 2 (high), and any other value gives 1 (low). `usr_cfg[1]` is 1 whenever `prot_lvl` is not 0.
- R7: In the configuration byte, bit 0 at 0 sets `wdt_auto_en`, bit 1 at 0 sets `rst_on_deepsleep`, and bit 2 at 0 sets `rst_on_standby`. Bits 7:3 only pass through into `usr_cfg`.
- R8: The first word holds the protection pair in bits 15:0 and the configuration pair in bits 31:16. The second word holds the user data pair in bits 15:0, and its bits 31:16 are ignored. Once `done` is high, `usr_cfg` carries {data byte, configuration byte, protection bit, `pair_err`} in bits 17:10, 9:2, 1 and 0. `pair_image` carries the stored pairs {data, configuration, protection}, 16 bits each, with the complement in the upper byte of each pair.
- R9: While `done` is low, `usr_cfg` reads 0x00002 and `pair_image` reads 0. In the same period `prot_lvl` is 1, and `wdt_auto_en`, `rst_on_deepsleep` and `rst_on_standby` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| rd_en | output | 1 | Read request to the information area |
| rd_addr | output | AW (16) | Byte address of the requested word |
| rd_data | input | 32 | Read word, valid the cycle after `rd_en` |
| done | output | 1 | Loading finished |
| pair_err | output | 1 | At least one pair failed the complement check |
| usr_cfg | output | 18 | User configuration register image |
| pair_image | output | 48 | Stored pairs after the check |
| prot_lvl | output | 2 | Protection level: 0 off, 1 low, 2 high |
| wdt_auto_en | output | 1 | Watchdog started automatically |
| rst_on_deepsleep | output | 1 | Reset on entering deep sleep |
| rst_on_standby | output | 1 | Reset on entering standby |

## Verification
The hardest states to reach from the ports are those where the only visible trace of a failure is the forced complement byte and the error bit. Examples are a bad complement paired with a valid value, or a 0x00/0x00 pair that sits right beside the accepted 0xFF/0xFF. The stimulus table places single-bit flips in each byte of each pair. It also sets an erased pair beside a zeroed pair, so that each of these outcomes appears in the image. A directed test resets in the middle of a load whose first word is corrupt, then reloads clean contents, which shows that the error does not outlive its reset.

// File: rtl/optld_pkg.sv
// Shared types and constants for the reset-time configuration loader.
// Assumes 8-bit value bytes, each paired with an 8-bit complement.
package optld_pkg;
    localparam int BYTE_W = 8;
    localparam int PAIR_W = 2 * BYTE_W;
    localparam logic [BYTE_W-1:0] PROT_KEY_OPEN = 8'hA5;
    localparam logic [BYTE_W-1:0] PROT_KEY_HIGH = 8'hCC;

    typedef enum logic [1:0] {
        PROT_NONE = 2'd0,
        PROT_LOW  = 2'd1,
        PROT_HIGH = 2'd2
    } prot_lvl_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_DONE  = 2'd3
    } seq_st_e;
endpackage

// File: rtl/optld_pair_check.sv
// Complement check for one value/complement pair (complement in the upper byte).
// A pair is accepted when the upper byte inverts the lower one, or when both
// bytes are all ones. A rejected pair is replaced by all ones.
// Purely combinational; assumes the caller decides when to capture the result.
module optld_pair_check #(
    parameter int BW = 8
) (
    input  logic [2*BW-1:0] pair_in,
    output logic            pair_ok,
    output logic [2*BW-1:0] pair_out
);
    logic [BW-1:0] val_b;
    logic [BW-1:0] inv_b;

    // split the pair and judge it
    always_comb begin
        val_b    = pair_in[BW-1:0];
        inv_b    = pair_in[2*BW-1:BW];
        pair_ok  = (inv_b == ~val_b) || (&pair_in);
        pair_out = pair_ok ? pair_in : '1;
    end
endmodule

// File: rtl/optld_seq.sv
// Load sequencer: one idle cycle after reset, then for every word a read
// request cycle followed by a capture cycle. The read port is assumed to
// return data exactly one cycle after the request.
module optld_seq
    import optld_pkg::*;
#(
    parameter int             N_WORDS   = 2,
    parameter int             AW        = 16,
    parameter logic [AW-1:0]  BASE_ADDR = 16'h0800,
    parameter int             ADDR_STEP = 4,
    localparam int            IW        = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          cap_en,
    output logic [IW-1:0] cap_idx,
    output logic          done
);
    seq_st_e       st_q;
    logic [IW-1:0] idx_q;

    // state and word index advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            idx_q <= '0;
        end else begin
            case (st_q)
                SQ_IDLE:  st_q <= SQ_ISSUE;
                SQ_ISSUE: st_q <= SQ_WAIT;
                SQ_WAIT: begin
                    if (idx_q == IW'(N_WORDS - 1)) begin
                        st_q <= SQ_DONE;
                    end else begin
                        st_q  <= SQ_ISSUE;
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default:  st_q <= SQ_DONE;
            endcase
        end
    end

    // request, capture and completion strobes
    always_comb begin
        rd_en   = (st_q == SQ_ISSUE);
        rd_addr = BASE_ADDR + (AW'(idx_q) * AW'(ADDR_STEP));
        cap_en  = (st_q == SQ_WAIT);
        cap_idx = idx_q;
        done    = (st_q == SQ_DONE);
    end
endmodule

// File: rtl/optld_decode.sv
// Turns the protection and configuration bytes into control outputs.
// While loading is incomplete it presents safe values: low-level protection,
// watchdog on, resets on low-power entry on.
module optld_decode
    import optld_pkg::*;
(
    input  logic              done,
    input  logic [BYTE_W-1:0] prot_byte,
    input  logic [BYTE_W-1:0] cfg_byte,
    output prot_lvl_e         prot_lvl,
    output logic              prot_on,
    output logic              wdt_auto_en,
    output logic              rst_on_deepsleep,
    output logic              rst_on_standby
);
    // level decode with safe values before completion
    always_comb begin
        if (!done) begin
            prot_lvl         = PROT_LOW;
            wdt_auto_en      = 1'b1;
            rst_on_deepsleep = 1'b1;
            rst_on_standby   = 1'b1;
        end else begin
            if (prot_byte == PROT_KEY_OPEN)      prot_lvl = PROT_NONE;
            else if (prot_byte == PROT_KEY_HIGH) prot_lvl = PROT_HIGH;
            else                                 prot_lvl = PROT_LOW;
            wdt_auto_en      = ~cfg_byte[0];
            rst_on_deepsleep = ~cfg_byte[1];
            rst_on_standby   = ~cfg_byte[2];
        end
        prot_on = (prot_lvl != PROT_NONE);
    end
endmodule

// File: rtl/optld_top.sv
// Reset-time configuration loader. Pair k lives in word k/2, half k%2.
// Pair 0 is protection, pair 1 is configuration, and the remaining pairs are
// user data bytes. Assumes N_PAIRS >= 2 and a read port with one cycle of latency.
module optld_top
    import optld_pkg::*;
#(
    parameter int             AW        = 16,
    parameter logic [AW-1:0]  BASE_ADDR = 16'h0800,
    parameter int             ADDR_STEP = 4,
    parameter int             N_PAIRS   = 3,
    localparam int            N_WORDS   = (N_PAIRS + 1) / 2,
    localparam int            DW        = 2 * PAIR_W,
    localparam int            CFG_W     = 2 + BYTE_W * (N_PAIRS - 1),
    localparam int            IMG_W     = PAIR_W * N_PAIRS,
    localparam int            IW        = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    rd_data,
    output logic             done,
    output logic             pair_err,
    output logic [CFG_W-1:0] usr_cfg,
    output logic [IMG_W-1:0] pair_image,
    output logic [1:0]       prot_lvl,
    output logic             wdt_auto_en,
    output logic             rst_on_deepsleep,
    output logic             rst_on_standby
);
    logic                         cap_en;
    logic [IW-1:0]                cap_idx;
    logic [1:0]                   half_ok;
    logic [1:0]                   half_used;
    logic [1:0][PAIR_W-1:0]       half_fix;
    logic [N_PAIRS-1:0][PAIR_W-1:0] pair_q;
    logic                         err_q;
    logic                         prot_on;
    prot_lvl_e                    lvl_e;

    optld_seq #(
        .N_WORDS  (N_WORDS),
        .AW       (AW),
        .BASE_ADDR(BASE_ADDR),
        .ADDR_STEP(ADDR_STEP)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .cap_en (cap_en),
        .cap_idx(cap_idx),
        .done   (done)
    );

    // one checker per half of the read word
    for (genvar h = 0; h < 2; h++) begin : g_half
        optld_pair_check #(.BW(BYTE_W)) u_chk (
            .pair_in (rd_data[h*PAIR_W +: PAIR_W]),
            .pair_ok (half_ok[h]),
            .pair_out(half_fix[h])
        );
        // a half counts only if it maps to a defined pair
        always_comb half_used[h] = (2 * int'(cap_idx) + h) < N_PAIRS;
    end

    // capture the checked pairs of the current word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '0;
        end else if (cap_en) begin
            for (int k = 0; k < N_PAIRS; k++) begin
                if (cap_idx == IW'(k / 2)) pair_q[k] <= half_fix[k % 2];
            end
        end
    end

    // sticky error flag, cleared by reset only
    always_ff @(posedge clk) begin
        if (!rst_n)                              err_q <= 1'b0;
        else if (cap_en && |(half_used & ~half_ok)) err_q <= 1'b1;
    end

    optld_decode u_dec (
        .done            (done),
        .prot_byte       (pair_q[0][BYTE_W-1:0]),
        .cfg_byte        (pair_q[1][BYTE_W-1:0]),
        .prot_lvl        (lvl_e),
        .prot_on         (prot_on),
        .wdt_auto_en     (wdt_auto_en),
        .rst_on_deepsleep(rst_on_deepsleep),
        .rst_on_standby  (rst_on_standby)
    );

    // register image and stored pairs, published only after completion
    always_comb begin
        usr_cfg = CFG_W'(2);
        if (done) begin
            usr_cfg[0] = err_q;
            usr_cfg[1] = prot_on;
            for (int k = 1; k < N_PAIRS; k++) begin
                usr_cfg[2 + BYTE_W*(k-1) +: BYTE_W] = pair_q[k][BYTE_W-1:0];
            end
        end
        pair_image = done ? pair_q : '0;
        prot_lvl   = lvl_e;
        pair_err   = err_q;
    end
endmodule

// File: rtl/optld_chk.sv
// Temporal checks on the loader's ports, attached to every optld_top instance.
module optld_chk #(
    parameter int CFG_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             done,
    input logic             pair_err,
    input logic [CFG_W-1:0] usr_cfg,
    input logic [1:0]       prot_lvl,
    input logic             wdt_auto_en,
    input logic             rst_on_deepsleep,
    input logic             rst_on_standby
);
    // R2
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    // R1
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
    // R1
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_en);
    // R9
    safe_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (prot_lvl == 2'd1 && wdt_auto_en && rst_on_deepsleep && rst_on_standby));
    // R8
    err_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (usr_cfg[0] == pair_err));
    // R6
    prot_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (usr_cfg[1] == (prot_lvl != 2'd0)));
    // R4
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_err |=> pair_err);
endmodule

bind optld_top optld_chk #(.CFG_W(CFG_W)) u_optld_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_en           (rd_en),
    .done            (done),
    .pair_err        (pair_err),
    .usr_cfg         (usr_cfg),
    .prot_lvl        (prot_lvl),
    .wdt_auto_en     (wdt_auto_en),
    .rst_on_deepsleep(rst_on_deepsleep),
    .rst_on_standby  (rst_on_standby)
);

// File: tb/sim_optld_top.sv
module sim_optld_top;
    localparam int          CLK_P = 10;
    localparam logic [15:0] BASE  = 16'h0800;

    typedef struct packed {
        logic [31:0] w0;
        logic [31:0] w1;
        logic [17:0] cfg;
        logic [47:0] img;
        logic [1:0]  lvl;
        logic [2:0]  ctl;   // {wdt_auto_en, rst_on_deepsleep, rst_on_standby}
        logic        err;
    } vec_t;

    localparam vec_t VECS [9] = '{
        // R6 open key, R7 all cfg bits set
        '{32'hF807_5AA5, 32'h0000_C33C, 18'h0F01C, 48'hC33C_F807_5AA5, 2'd0, 3'b000, 1'b0},
        // R6 high key, R10-style ignored upper half of word 1 (R8)
        '{32'hFF00_33CC, 32'hDEAD_FF00, 18'h00002, 48'hFF00_FF00_33CC, 2'd2, 3'b111, 1'b0},
        // R6 other value, R7 only deep-sleep bit set
        '{32'hFD02_ED12, 32'h0000_7E81, 18'h2040A, 48'h7E81_FD02_ED12, 2'd1, 3'b101, 1'b0},
        // R3 fully erased contents accepted
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 18'h3FFFE, 48'hFFFF_FFFF_FFFF, 2'd1, 3'b000, 1'b0},
        // R4 flip in protection complement
        '{32'hF807_5BA5, 32'h0000_C33C, 18'h0F01F, 48'hC33C_F807_FFFF, 2'd1, 3'b000, 1'b1},
        // R4 flip in configuration value
        '{32'hF805_5AA5, 32'h0000_C33C, 18'h0F3FD, 48'hC33C_FFFF_5AA5, 2'd0, 3'b000, 1'b1},
        // R4 flip in data complement
        '{32'hFF00_33CC, 32'h0000_FE00, 18'h3FC03, 48'hFFFF_FF00_33CC, 2'd2, 3'b111, 1'b1},
        // R3 zeroed pair rejected beside erased pair
        '{32'hFFFF_0000, 32'h0000_A55A, 18'h16BFF, 48'hA55A_FFFF_FFFF, 2'd1, 3'b000, 1'b1},
        // R6 near-key value, R7 only standby bit set
        '{32'hFB04_5BA4, 32'h0000_FF00, 18'h00012, 48'hFF00_FB04_5BA4, 2'd1, 3'b110, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [31:0] rd_data = '0;
    logic        done;
    logic        pair_err;
    logic [17:0] usr_cfg;
    logic [47:0] pair_image;
    logic [1:0]  prot_lvl;
    logic        wdt_auto_en;
    logic        rst_on_deepsleep;
    logic        rst_on_standby;

    logic [31:0] mem_w0 = '0;
    logic [31:0] mem_w1 = '0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    optld_top u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .rd_en           (rd_en),
        .rd_addr         (rd_addr),
        .rd_data         (rd_data),
        .done            (done),
        .pair_err        (pair_err),
        .usr_cfg         (usr_cfg),
        .pair_image      (pair_image),
        .prot_lvl        (prot_lvl),
        .wdt_auto_en     (wdt_auto_en),
        .rst_on_deepsleep(rst_on_deepsleep),
        .rst_on_standby  (rst_on_standby)
    );

    // information area model with one cycle of read latency
    always @(posedge clk) begin
        if (rd_en) begin
            if (rd_addr == BASE)            rd_data <= mem_w0;
            else if (rd_addr == BASE + 16'd4) rd_data <= mem_w1;
            else                            rd_data <= 32'h0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // reset, load contents, follow the read sequence to completion
    task automatic run_load(input logic [31:0] w0, input logic [31:0] w1);
        @(negedge clk);
        rst_n  = 1'b0;
        mem_w0 = w0;
        mem_w1 = w1;
        step();
        step();
        rst_n = 1'b1;
        for (int k = 0; k <= 6; k++) begin
            chk("R1", "rd_en", 64'(rd_en), 64'((k % 2 == 1) && (k < 5)));
            if (rd_en)
                chk("R1", "rd_addr", 64'(rd_addr), 64'(BASE + 16'((k - 1) / 2 * 4)));
            chk("R2", "done", 64'(done), 64'(k >= 5));
            if (k == 0) begin
                chk("R5", "pair_err after reset", 64'(pair_err), 64'(0));
                chk("R9", "usr_cfg while loading", 64'(usr_cfg), 64'(18'h00002));
                chk("R9", "pair_image while loading", 64'(pair_image), 64'(0));
                chk("R9", "controls while loading",
                    64'({prot_lvl, wdt_auto_en, rst_on_deepsleep, rst_on_standby}),
                    64'({2'd1, 3'b111}));
            end
            if (k < 6) step();
        end
    endtask

    task automatic check_vec(input vec_t v);
        chk("R8", "usr_cfg", 64'(usr_cfg), 64'(v.cfg));
        chk("R4", "pair_image", 64'(pair_image), 64'(v.img));
        chk("R3", "pair_err", 64'(pair_err), 64'(v.err));
        chk("R6", "prot_lvl", 64'(prot_lvl), 64'(v.lvl));
        chk("R7", "controls", 64'({wdt_auto_en, rst_on_deepsleep, rst_on_standby}), 64'(v.ctl));
    endtask

    initial begin
        #(CLK_P * 50000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // table walk: each vector is a full reset and load
        foreach (VECS[i]) begin
            run_load(VECS[i].w0, VECS[i].w1);
            check_vec(VECS[i]);
        end

        // R5: contents changed after done have no effect without reset
        run_load(VECS[0].w0, VECS[0].w1);
        mem_w0 = VECS[6].w0;
        mem_w1 = VECS[6].w1;
        for (int j = 0; j < 4; j++) step();
        chk("R5", "rd_en idle after done", 64'(rd_en), 64'(0));
        check_vec(VECS[0]);

        // R5: reset mid-load with a corrupt first word, then a clean reload
        @(negedge clk);
        rst_n  = 1'b0;
        mem_w0 = VECS[4].w0;
        mem_w1 = VECS[4].w1;
        step();
        rst_n = 1'b1;
        for (int j = 0; j < 3; j++) step();
        chk("R4", "pair_err after first capture", 64'(pair_err), 64'(1));
        chk("R2", "done mid-load", 64'(done), 64'(0));
        run_load(VECS[2].w0, VECS[2].w1);
        check_vec(VECS[2]);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule